// File: doc/BRIEF.md
# Configurable Routing Switch Matrix

This block is the routing node of a small reconfigurable fabric. It meets neighbouring nodes on four sides, north, east, south and west. Every side carries `NP` short wires, which run to the adjacent node, and `NP` long wires, which skip one node and reach the node beyond it. Short wire *i* and long wire *i* form channel pair *i*. A signal may only move between wires of the same index, so a net crosses the fabric on one short/long pair. The node also serves one attached logic block: it can inject that block's outputs onto a pair, and it feeds the block's inputs from wires it picks.

A small configuration store sets the routing. There is one entry per channel pair and one entry per logic-block input. A pair entry picks a single source for the pair and gives a per-side enable for each short and each long output wire. A tap entry names the side and the wire that feed one logic-block input. A pair entry that would drive a wire from itself is a contention. So is an unknown source code. Each such case is reported on a per-pair error output and is not resolved silently. All outputs are registered.

Top module: `sm_switch_matrix`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, every output is 0. Reset also clears every configuration entry to all zeros.
- R2: A pair entry is 12 bits: source code in bits [3:0], short-output enables per side in bits [7:4], long-output enables per side in bits [11:8]. The side order is north=0, east=1, south=2, west=3. For pair *p*, an enabled short output on side *s* shows the selected source bit one clock after the inputs are applied.
- R3: Long outputs of pair *p* follow their enables in the same way as short outputs. Source codes 0–3 select the short input of sides 0–3, codes 4–7 select the long input of sides 0–3, and code 8 selects the logic block's output bit *p*.
- R4: Wire *s·NP+p* of every side bus belongs to pair *p*. Outputs of pair *p* depend only on inputs of pair *p* and on logic-block output bit *p*.
- R5: A wire whose enable bit is clear drives 0.
- R6: If the source is a side's short (long) input and that side's short (long) output enable is also set, that one output drives 0. The pair's error bit is 1 one clock later. The other enabled outputs of the pair still carry the source.
- R7: Source codes 9–15 are invalid. With an invalid code, all outputs of the pair drive 0 and its error bit is 1.
- R8: Logic-block input *k* is set by configuration entry NP+k. The pair index is in the low bits, the next bit selects long (1) or short (0), and the two bits above that give the side. The input shows that wire's value one clock later.
- R9: A configuration write to an address of NP+NLB or above changes nothing.
- R10: A write at one clock edge takes effect on the outputs registered at the next edge. Input changes reach the outputs after exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(NP+NLB)+1 | Configuration entry address |
| cfg_wdata | input | 12 | Configuration entry data |
| short_in | input | 4*NP | Incoming short wires, bit s*NP+p |
| long_in | input | 4*NP | Incoming long wires, bit s*NP+p |
| blk_dout | input | NP | Logic block outputs, one per pair |
| short_out | output | 4*NP | Outgoing short wires |
| long_out | output | 4*NP | Outgoing long wires |
| blk_din | output | NLB | Inputs fed to the logic block |
| route_err | output | NP | Per-pair contention or invalid-code flag |

## Verification
The bench builds the block with two channel pairs and two logic-block inputs. This keeps the space small enough to try every one of the sixteen source codes with all 256 enable patterns on each pair, while the other pair holds its last setting. With two taps over four sides and four wires, every tap selection is also tried. All four spare configuration addresses are written to show they are ignored. Fresh pseudo-random inputs are applied each cycle, so isolation between pairs and the one-cycle latency are checked on every one of these settings.

// File: rtl/sm_pkg.sv
package sm_pkg;
  localparam int SIDES = 4;
  localparam int SRC_W = 4;
  localparam int CFG_W = SRC_W + 2 * SIDES;
  localparam logic [SRC_W-1:0] SRC_LOCAL = 4'd8;

  typedef struct packed {
    logic [SIDES-1:0] long_en;
    logic [SIDES-1:0] short_en;
    logic [SRC_W-1:0] src;
  } pair_cfg_t;
endpackage

// File: rtl/sm_cfg_store.sv
module sm_cfg_store #(
  parameter int NENT = 8,
  parameter int AW   = 4,
  parameter int CW   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [AW-1:0]      addr,
  input  logic [CW-1:0]      wdata,
  output logic [NENT*CW-1:0] cfg_flat
);
  logic [CW-1:0] mem [NENT];

  // Addresses with no matching entry fall through untouched.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < NENT; e++) mem[e] <= '0;
    end else if (we) begin
      for (int e = 0; e < NENT; e++)
        if (addr == AW'(e)) mem[e] <= wdata;
    end
  end

  for (genvar e = 0; e < NENT; e++) begin : g_flat
    assign cfg_flat[e*CW +: CW] = mem[e];
  end
endmodule

// File: rtl/sm_pair_route.sv
module sm_pair_route
  import sm_pkg::*;
#(
  parameter int NP = 4,
  parameter int P  = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SIDES*NP-1:0] short_in,
  input  logic [SIDES*NP-1:0] long_in,
  input  logic                blk_bit,
  input  logic [CFG_W-1:0]    cfg,
  output logic [SIDES-1:0]    short_o,
  output logic [SIDES-1:0]    long_o,
  output logic                err
);
  pair_cfg_t        c;
  logic [SIDES-1:0] sh_t, lo_t;
  logic [SIDES-1:0] sel_s, sel_l;
  logic [SIDES-1:0] clash_s, clash_l;
  logic             is_local, valid, pick;

  assign c = pair_cfg_t'(cfg);

  // Gather this pair's wire from each side and decode the source one-hot.
  for (genvar s = 0; s < SIDES; s++) begin : g_side
    assign sh_t[s]    = short_in[s*NP + P];
    assign lo_t[s]    = long_in[s*NP + P];
    assign sel_s[s]   = (c.src == SRC_W'(s));
    assign sel_l[s]   = (c.src == SRC_W'(s + SIDES));
    assign clash_s[s] = sel_s[s] & c.short_en[s];
    assign clash_l[s] = sel_l[s] & c.long_en[s];
  end

  assign is_local = (c.src == SRC_LOCAL);
  assign valid    = (c.src <= SRC_LOCAL);
  assign pick     = (|(sel_s & sh_t)) | (|(sel_l & lo_t)) | (is_local & blk_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      short_o <= '0;
      long_o  <= '0;
      err     <= 1'b0;
    end else begin
      short_o <= {SIDES{valid & pick}} & c.short_en & ~clash_s;
      long_o  <= {SIDES{valid & pick}} & c.long_en & ~clash_l;
      err     <= ~valid | (|clash_s) | (|clash_l);
    end
  end
endmodule

// File: rtl/sm_local_tap.sv
module sm_local_tap
  import sm_pkg::*;
#(
  parameter int NP = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SIDES*NP-1:0] short_in,
  input  logic [SIDES*NP-1:0] long_in,
  input  logic [CFG_W-1:0]    cfg,
  output logic                tap
);
  localparam int PIW = (NP > 1) ? $clog2(NP) : 1;

  logic [PIW-1:0]      pr;
  logic                lng;
  logic [1:0]          side;
  logic [SIDES*NP-1:0] hit;
  logic                val;

  assign pr   = cfg[PIW-1:0];
  assign lng  = cfg[PIW];
  assign side = cfg[PIW+2:PIW+1];

  for (genvar s = 0; s < SIDES; s++) begin : g_s
    for (genvar i = 0; i < NP; i++) begin : g_i
      assign hit[s*NP + i] = (side == 2'(s)) && (pr == PIW'(i));
    end
  end

  assign val = |(hit & (lng ? long_in : short_in));

  always_ff @(posedge clk) begin
    if (rst) tap <= 1'b0;
    else     tap <= val;
  end
endmodule

// File: rtl/sm_switch_matrix.sv
module sm_switch_matrix
  import sm_pkg::*;
#(
  parameter  int NP   = 4,
  parameter  int NLB  = 4,
  localparam int NENT = NP + NLB,
  localparam int AW   = $clog2(NENT) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [AW-1:0]       cfg_addr,
  input  logic [CFG_W-1:0]    cfg_wdata,
  input  logic [SIDES*NP-1:0] short_in,
  input  logic [SIDES*NP-1:0] long_in,
  input  logic [NP-1:0]       blk_dout,
  output logic [SIDES*NP-1:0] short_out,
  output logic [SIDES*NP-1:0] long_out,
  output logic [NLB-1:0]      blk_din,
  output logic [NP-1:0]       route_err
);
  logic [NENT*CFG_W-1:0] cfg_flat;

  sm_cfg_store #(.NENT(NENT), .AW(AW), .CW(CFG_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .cfg_flat (cfg_flat)
  );

  for (genvar p = 0; p < NP; p++) begin : g_pair
    logic [SIDES-1:0] so, lo;

    sm_pair_route #(.NP(NP), .P(p)) u_route (
      .clk      (clk),
      .rst      (rst),
      .short_in (short_in),
      .long_in  (long_in),
      .blk_bit  (blk_dout[p]),
      .cfg      (cfg_flat[p*CFG_W +: CFG_W]),
      .short_o  (so),
      .long_o   (lo),
      .err      (route_err[p])
    );

    for (genvar s = 0; s < SIDES; s++) begin : g_map
      assign short_out[s*NP + p] = so[s];
      assign long_out[s*NP + p]  = lo[s];
    end
  end

  for (genvar k = 0; k < NLB; k++) begin : g_tap
    sm_local_tap #(.NP(NP)) u_tap (
      .clk      (clk),
      .rst      (rst),
      .short_in (short_in),
      .long_in  (long_in),
      .cfg      (cfg_flat[(NP+k)*CFG_W +: CFG_W]),
      .tap      (blk_din[k])
    );
  end
endmodule

// File: rtl/sm_switch_matrix_chk.sv
module sm_switch_matrix_chk
  import sm_pkg::*;
#(
  parameter  int NP   = 4,
  parameter  int NLB  = 4,
  localparam int NENT = NP + NLB,
  localparam int AW   = $clog2(NENT) + 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cfg_we,
  input logic [AW-1:0]         cfg_addr,
  input logic [SIDES*NP-1:0]   short_in,
  input logic [SIDES*NP-1:0]   long_in,
  input logic [NP-1:0]         blk_dout,
  input logic [SIDES*NP-1:0]   short_out,
  input logic [SIDES*NP-1:0]   long_out,
  input logic [NLB-1:0]        blk_din,
  input logic [NP-1:0]         route_err,
  input logic [NENT*CFG_W-1:0] cfg_flat
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (short_out == '0 && long_out == '0 && blk_din == '0 && route_err == '0));

  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(short_in) == '0 && $past(long_in) == '0 && $past(blk_dout) == '0)
    |-> (short_out == '0 && long_out == '0 && blk_din == '0));

  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(cfg_we, 2) && !$past(rst) && !$past(rst, 2)) |-> $stable(route_err));

  // R9
  cfg_oob_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_we) && !$past(rst) && $past(cfg_addr) >= AW'(NENT)) |-> $stable(cfg_flat));
endmodule

bind sm_switch_matrix sm_switch_matrix_chk #(.NP(NP), .NLB(NLB)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .short_in  (short_in),
  .long_in   (long_in),
  .blk_dout  (blk_dout),
  .short_out (short_out),
  .long_out  (long_out),
  .blk_din   (blk_din),
  .route_err (route_err),
  .cfg_flat  (cfg_flat)
);

// File: tb/sim_sm_switch_matrix.sv
module sim_sm_switch_matrix;
  import sm_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NP   = 2;
  localparam int NLB  = 2;
  localparam int NENT = NP + NLB;
  localparam int AW   = 3;
  localparam int NW   = SIDES * NP;

  logic             clk = 1'b0;
  logic             rst;
  logic             cfg_we;
  logic [AW-1:0]    cfg_addr;
  logic [CFG_W-1:0] cfg_wdata;
  logic [NW-1:0]    short_in, long_in, short_out, long_out;
  logic [NP-1:0]    blk_dout, route_err;
  logic [NLB-1:0]   blk_din;

  int checks = 0;
  int errors = 0;
  logic [CFG_W-1:0] mcfg [NENT];
  logic [31:0] lfsr = 32'h1234_5678;
  logic [NW-1:0]  e_so, e_lo;
  logic [NP-1:0]  e_err;
  logic [NLB-1:0] e_din;

  always #(CLK_PERIOD/2) clk = ~clk;

  sm_switch_matrix #(.NP(NP), .NLB(NLB)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .short_in(short_in), .long_in(long_in), .blk_dout(blk_dout),
    .short_out(short_out), .long_out(long_out), .blk_din(blk_din), .route_err(route_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected outputs from the requirement text, for the inputs now applied.
  task automatic model();
    e_so = '0; e_lo = '0; e_err = '0; e_din = '0;
    for (int p = 0; p < NP; p++) begin
      int src = int'(mcfg[p][3:0]);
      logic [3:0] es = mcfg[p][7:4];
      logic [3:0] el = mcfg[p][11:8];
      logic b = 1'b0;
      if (src < 4)       b = short_in[src*NP + p];
      else if (src < 8)  b = long_in[(src-4)*NP + p];
      else if (src == 8) b = blk_dout[p];
      for (int s = 0; s < SIDES; s++) begin
        e_so[s*NP + p] = (src <= 8) && es[s] && (src != s) && b;
        e_lo[s*NP + p] = (src <= 8) && el[s] && (src != s + 4) && b;
      end
      e_err[p] = (src > 8) || (src < 4 && es[src]) || (src >= 4 && src < 8 && el[src-4]);
    end
    for (int k = 0; k < NLB; k++) begin
      int pr   = int'(mcfg[NP+k][0]);
      int side = int'(mcfg[NP+k][3:2]);
      e_din[k] = mcfg[NP+k][1] ? long_in[side*NP + pr] : short_in[side*NP + pr];
    end
  endtask

  task automatic drive_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    short_in = lfsr[7:0];
    long_in  = lfsr[15:8];
    blk_dout = lfsr[17:16];
  endtask

  // Called at a falling edge; outputs are compared one clock later (R10).
  task automatic step(input string base);
    drive_rand();
    model();
    @(negedge clk);
    chk({base, " R2 R4 R5 R6 R10 short_out"}, 32'(short_out), 32'(e_so));
    chk({base, " R3 R4 R5 R10 long_out"},     32'(long_out),  32'(e_lo));
    chk({base, " R6 R7 route_err"},           32'(route_err), 32'(e_err));
    chk({base, " R8 blk_din"},                32'(blk_din),   32'(e_din));
  endtask

  task automatic write_cfg(input int addr, input logic [CFG_W-1:0] data);
    cfg_we    = 1'b1;
    cfg_addr  = AW'(addr);
    cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr < NENT) mcfg[addr] = data;
  endtask

  task automatic chk_zero(input string tag);
    chk({tag, " R1 short_out"}, 32'(short_out), 32'h0);
    chk({tag, " R1 long_out"},  32'(long_out),  32'h0);
    chk({tag, " R1 blk_din"},   32'(blk_din),   32'h0);
    chk({tag, " R1 route_err"}, 32'(route_err), 32'h0);
  endtask

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    short_in = '0; long_in = '0; blk_dout = '0;
    for (int e = 0; e < NENT; e++) mcfg[e] = '0;
    repeat (3) @(negedge clk);
    chk_zero("reset");
    rst = 1'b0;
    step("R1 cleared-config");

    // R2 R3 R5 R6 R7: every source code with every enable pattern, per pair
    for (int p = 0; p < NP; p++)
      for (int src = 0; src < 16; src++)
        for (int en = 0; en < 256; en++) begin
          write_cfg(p, {en[7:0], src[3:0]});
          step("sweep");
          step("sweep-next");
        end

    // R8: every side and wire for each logic-block input
    for (int k = 0; k < NLB; k++)
      for (int side = 0; side < SIDES; side++)
        for (int ch = 0; ch < 4; ch++) begin
          write_cfg(NP + k, CFG_W'({side[1:0], ch[1:0]}));
          step("tap");
          step("tap-next");
          step("tap-again");
        end

    // R9: spare addresses are ignored
    for (int a = NENT; a < (1 << AW); a++) begin
      write_cfg(a, '1);
      step("R9 spare-addr");
    end

    // R1: reset mid-run clears outputs and configuration
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk_zero("mid-reset");
    rst = 1'b0;
    for (int e = 0; e < NENT; e++) mcfg[e] = '0;
    step("R1 after mid-reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule